// File: doc/BRIEF.md
# Double-Buffered PWM Generator

This block produces one pulse-width-modulated output from a free-running counter. The counter runs from zero up to a programmed period and then wraps. The output is high from the start of each cycle until the count reaches a programmed duty value. Software sets the period and the duty value through a byte-wide register port. Each value is wider than one byte, so each is written in byte pieces.

Writing a lower byte only stores that byte. Writing the top byte combines it with the stored lower bytes into a full value and marks that value as pending. Pending values move into the active compare registers only at the cycle boundary, where the counter wraps. A change made in the middle of a cycle therefore never shortens or stretches the cycle in progress. Register reads always return the bytes as they were last written, whether or not they have reached the active registers.

A flag is set at every wrap and can drive an interrupt. A separate run input freezes the counter.

Top module: `pwm_shadow_gen`

## Requirements
- R1: After reset the output and the interrupt are low, the counter is zero, and every register address (0 to 5) reads back zero.
- R2: A write to a low byte (address 0 for period, address 2 for duty) stores only that byte. It leaves the active and the pending value unchanged, and nothing is transferred at the next boundary.
- R3: A write to the high byte (address 1 for period, address 3 for duty) forms the 16-bit value from that byte and the stored low byte, and marks it pending. The value becomes active at the next cycle boundary.
- R4: The active period and duty change only at a cycle boundary. A commit made during a cycle leaves that cycle's high time and length unchanged.
- R5: Reading addresses 0 to 3 returns the bytes last written there, whether or not they have been transferred.
- R6: While running, the counter steps by one each clock from 0 up to the active period, then returns to 0. A cycle lasts period+1 clocks.
- R7: The output is high while the count is below the active duty value and low otherwise. Duty 0 gives a constant low output, and a duty above the period gives a constant high output. The output is registered, so it follows the count one clock later.
- R8: Control register (address 4) bit 0 enables the output. While this bit is clear, the output is low.
- R9: A cycle-end flag (address 5, bit 0) is set at every wrap and is cleared by writing 1 to that bit. If a wrap and a clear happen together, the set wins. The interrupt equals the flag ANDed with control bit 1.
- R10: While run_en is low, the counter holds, no wrap occurs, no flag is set and no pending value is transferred.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| run_en | input | 1 | Counter run enable |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | Cycle-end interrupt |

## Verification
The assertions assume that reg_wr, reg_addr and run_en hold known values whenever reset is released. They also assume that the only way state reaches a known value is the synchronized reset. Given those, the count never exceeds the active period and the active registers move only on a wrap.

The stimulus drives every input at the falling clock edge from defined values. It never leaves the write strobe floating. It toggles run_en only in the phase that checks the frozen counter. The bench makes its duty measurements over whole multiples of the cycle length, so the one-clock output delay does not affect the counts.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    RSEL_PER,
    RSEL_DUTY,
    RSEL_CTRL,
    RSEL_FLAG,
    RSEL_NONE
  } rsel_e;

  typedef struct packed {
    logic irq_en;
    logic out_en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg
  import pwm_shadow_pkg::*;
#(
  parameter  int unsigned CW = 16,
  localparam int unsigned NB = CW / BYTE_W,
  localparam int unsigned IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     byte_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              wrap,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [CW-1:0]     act_val
);

  logic [NB-1:0][BYTE_W-1:0] byte_q;
  logic [NB-1:0][BYTE_W-1:0] byte_d;
  logic [NB-1:0]             lane_wr;
  logic [CW-1:0]             shadow_q, shadow_d;
  logic [CW-1:0]             act_q, act_d;
  logic [CW-1:0]             commit_val;
  logic                      pend_q, pend_d;
  logic                      commit;

  // one lane per byte of the written value
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane_wr[g] = wr_en && (byte_idx == IW'(g));
    assign byte_d[g]  = lane_wr[g] ? wr_data : byte_q[g];
  end

  // the top byte is the commit point
  assign commit = wr_en && (byte_idx == IW'(NB - 1));

  always_comb begin
    commit_val                 = byte_q;
    commit_val[CW-1 -: BYTE_W] = wr_data;
    shadow_d                   = commit ? commit_val : shadow_q;
    act_d                      = (wrap && pend_q) ? shadow_q : act_q;
    pend_d                     = commit | (pend_q & ~wrap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q   <= '0;
      shadow_q <= '0;
      act_q    <= '0;
      pend_q   <= 1'b0;
    end else begin
      for (int i = 0; i < NB; i++) begin
        if (lane_wr[i]) byte_q[i] <= byte_d[i];
      end
      if (commit) shadow_q <= shadow_d;
      if (wrap)   act_q    <= act_d;
      pend_q <= pend_d;
    end
  end

  assign rd_byte = byte_q[byte_idx];
  assign act_val = act_q;

  AST_LOW_WRITE_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !commit && !wrap) |=> (pend_q == $past(pend_q))); // R2
  AST_LOW_WRITE_KEEPS_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !commit) |=> $stable(shadow_q)); // R2
  AST_COMMIT_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> pend_q); // R3
  AST_ACT_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(act_q)); // R4

endmodule

// File: rtl/pwm_cycle_ctr.sv
module pwm_cycle_ctr #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic [CW-1:0] per_act,
  output logic [CW-1:0] cnt,
  output logic          wrap
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wrap  = run_en && (cnt_q == per_act);
    cnt_d = wrap ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (run_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= per_act); // R6
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0)); // R6
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !wrap) |=> (cnt_q == $past(cnt_q) + CW'(1))); // R6
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(cnt_q)); // R10

endmodule

// File: rtl/pwm_shadow_gen.sv
module pwm_shadow_gen
  import pwm_shadow_pkg::*;
#(
  parameter  int unsigned CW = 16,
  localparam int unsigned NB = CW / BYTE_W,
  localparam int unsigned IW = (NB > 1) ? $clog2(NB) : 1,
  localparam int unsigned AW = $clog2(2 * NB + 2)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              run_en,
  input  logic [AW-1:0]     reg_addr,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              pwm_o,
  output logic              irq_o
);

  localparam int unsigned A_CTRL = 2 * NB;
  localparam int unsigned A_FLAG = 2 * NB + 1;
  localparam int unsigned NCH    = 2;

  logic              rst_n;
  rsel_e             rsel;
  logic [IW-1:0]     ridx;
  logic [CW-1:0]     chan_act [NCH];
  logic [BYTE_W-1:0] chan_rd  [NCH];
  logic [CW-1:0]     cnt;
  logic              wrap;
  ctrl_t             ctrl_q, ctrl_d;
  logic              ctrl_wr;
  logic              flag_q, flag_d, flag_clr;
  logic              pwm_q, pwm_d;
  logic              pwm_raw;

  pwm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  // address decode: period bytes, duty bytes, control, flag
  always_comb begin
    rsel = RSEL_NONE;
    ridx = '0;
    if (reg_addr < AW'(NB)) begin
      rsel = RSEL_PER;
      ridx = IW'(reg_addr);
    end else if (reg_addr < AW'(2 * NB)) begin
      rsel = RSEL_DUTY;
      ridx = IW'(reg_addr - AW'(NB));
    end else if (reg_addr == AW'(A_CTRL)) begin
      rsel = RSEL_CTRL;
    end else if (reg_addr == AW'(A_FLAG)) begin
      rsel = RSEL_FLAG;
    end
  end

  // channel 0 holds the period, channel 1 the duty value
  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic ch_wr;
    assign ch_wr = reg_wr && (rsel == ((ch == 0) ? RSEL_PER : RSEL_DUTY));

    pwm_shadow_reg #(.CW(CW)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ch_wr),
      .byte_idx (ridx),
      .wr_data  (reg_wdata),
      .wrap     (wrap),
      .rd_byte  (chan_rd[ch]),
      .act_val  (chan_act[ch])
    );
  end

  pwm_cycle_ctr #(.CW(CW)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .per_act (chan_act[0]),
    .cnt     (cnt),
    .wrap    (wrap)
  );

  always_comb begin
    ctrl_wr  = reg_wr && (rsel == RSEL_CTRL);
    ctrl_d   = ctrl_t'(reg_wdata[CTRL_W-1:0]);
    flag_clr = reg_wr && (rsel == RSEL_FLAG) && reg_wdata[0];
    flag_d   = wrap | (flag_q & ~flag_clr);
    pwm_raw  = cnt < chan_act[1];
    pwm_d    = pwm_raw & ctrl_q.out_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
      pwm_q  <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_d;
      flag_q <= flag_d;
      pwm_q  <= pwm_d;
    end
  end

  always_comb begin
    unique case (rsel)
      RSEL_PER:  reg_rdata = chan_rd[0];
      RSEL_DUTY: reg_rdata = chan_rd[1];
      RSEL_CTRL: reg_rdata = {{(BYTE_W-CTRL_W){1'b0}}, ctrl_q};
      RSEL_FLAG: reg_rdata = {{(BYTE_W-1){1'b0}}, flag_q};
      default:   reg_rdata = '0;
    endcase
  end

  assign pwm_o = pwm_q;
  assign irq_o = flag_q & ctrl_q.irq_en;

  AST_OE_GATES_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.out_en |=> !pwm_q); // R8
  AST_DUTY_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_act[1] == '0) |=> !pwm_q); // R7
  AST_DUTY_OVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.out_en && (chan_act[1] > chan_act[0])) |=> pwm_q); // R7
  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag_q); // R9

endmodule

// File: tb/pwm_shadow_gen_bench.sv
module pwm_shadow_gen_bench;

  logic       clk;
  logic       rst_ni;
  logic       run_en;
  logic [2:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       pwm_o;
  logic       irq_o;

  int n_chk  = 0;
  int n_fail = 0;

  pwm_shadow_gen u_pwm_shadow_gen (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .run_en    (run_en),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pwm_o     (pwm_o),
    .irq_o     (irq_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_addr  = 3'(a);
    reg_wdata = 8'(d);
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    reg_addr = 3'(a);
    reg_wr   = 1'b0;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwm_o) h++;
    end
  endtask

  task automatic count_irq(input int n, output int h);
    h = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (irq_o) h++;
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int v, h, p0, exp_h, waited;

    rst_ni    = 1'b0;
    run_en    = 1'b0;
    reg_addr  = '0;
    reg_wr    = 1'b0;
    reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 pwm", int'(pwm_o), 0);
    chk("R1 irq", int'(irq_o), 0);
    for (int a = 0; a < 6; a++) begin
      rd(a, v);
      chk("R1 readback", v, 0);
    end

    run_en = 1'b1;
    wr(4, 1);  // output enable only

    // R6/R7/R3: sweep period 0..7 and duty 0..9
    for (int p = 0; p < 8; p++) begin
      for (int d = 0; d < 10; d++) begin
        wr(0, p); wr(1, 0);
        wr(2, d); wr(3, 0);
        repeat (20) @(negedge clk);
        count_high(3 * (p + 1), h);
        exp_h = 3 * ((d < p + 1) ? d : p + 1);
        chk("R7 R6 R3 high count", h, exp_h);
        if (d == p) begin
          rd(0, v); chk("R5 period low", v, p);
          rd(2, v); chk("R5 duty low", v, d);
        end
      end
    end

    // R4: mid-cycle duty change with period 99, duty 50
    wr(0, 99); wr(1, 0);
    wr(2, 50); wr(3, 0);
    repeat (20) @(negedge clk);
    wr(4, 3);
    wr(5, 1);
    waited = 0;
    while (!irq_o && waited < 300) begin
      @(negedge clk);
      waited++;
    end
    chk("R9 irq seen", int'(irq_o), 1);
    fork
      count_high(100, h);
      begin
        repeat (10) @(negedge clk);
        wr(2, 20); wr(3, 0);
      end
    join
    chk("R4 current cycle untouched", h, 50);
    fork
      count_high(100, h);
      begin
        repeat (10) @(negedge clk);
        wr(2, 5);  // low byte only
      end
    join
    chk("R3 commit applied at boundary", h, 20);
    count_high(100, h);
    chk("R2 low byte not transferred", h, 20);
    rd(2, v); chk("R5 duty low readback", v, 5);
    rd(3, v); chk("R5 duty high readback", v, 0);
    rd(0, v); chk("R5 period low readback", v, 99);

    // R9: interrupt masked while flag still sets
    wr(4, 1);
    count_irq(120, h);
    chk("R9 irq masked", h, 0);
    rd(5, v); chk("R9 flag set", v, 1);
    rd(4, v); chk("R8 ctrl readback", v, 1);

    // R10: counter frozen
    @(negedge clk);
    run_en = 1'b0;
    wr(5, 1);
    rd(5, v); chk("R9 flag cleared", v, 0);
    p0 = int'(pwm_o);
    count_high(50, h);
    chk("R10 output frozen", h, p0 * 50);
    rd(5, v); chk("R10 no wrap while idle", v, 0);
    @(negedge clk);
    run_en = 1'b1;

    // R8: output enable
    wr(4, 0);
    repeat (2) @(negedge clk);
    count_high(100, h);
    chk("R8 disabled output low", h, 0);
    wr(4, 1);
    repeat (2) @(negedge clk);
    count_high(100, h);
    chk("R8 enabled output", h, 20);

    // R9: interrupt enabled
    wr(4, 3);
    count_irq(120, h);
    chk("R9 irq raised", int'(h > 0), 1);

    summary();
    $finish;
  end

endmodule